// File: doc/BRIEF.md
# Protection Tuple Generator

This block sits in a storage write path and stamps end-to-end protection information into a byte stream. The stream carries a run of logical blocks, one byte per accepted cycle; each block is a fixed number of data bytes followed by a fixed number of metadata bytes. For every block the generator computes a guard checksum over the data and writes a protection tuple into that block's metadata. The tuple holds the guard, an application tag and a reference tag. All other bytes are forwarded unchanged, one cycle after they are accepted.

Two tuple formats are selectable at start. The narrow format uses a 16-bit CRC and a 32-bit reference tag in 8 bytes. The wide format uses a reflected 64-bit CRC and a 48-bit reference tag in 16 bytes. The tuple can sit at the head of the metadata or at its tail. When it sits at the tail, the metadata bytes ahead of it are folded into the guard after the data. The reference tag advances per block unless the protection type says it is fixed.

Control is a small state machine with three states. `ST_IDLE` waits for `start`, which loads the configuration and the initial tags. `ST_DATA` accepts the data bytes of a block; after its last data byte it moves to `ST_META`. `ST_META` accepts the metadata bytes. After the last metadata byte it returns to `ST_DATA` if more blocks remain, and to `ST_IDLE` otherwise, with a `done` pulse.

Top module: `pi_tuple_gen`

## Requirements
- R1: After reset `out_valid` and `done` are low. While the block is idle, `in_valid` is ignored and produces no output.
- R2: Every byte accepted (`in_valid` high while busy) appears on `out_byte` with `out_valid` high exactly one cycle later. Data bytes are unchanged. Cycles with `in_valid` low produce no output and do not advance the stream.
- R3: With `cfg_wide`=0 the guard is a CRC with polynomial 0x8BB7, zero seed, most significant bit first and no final inversion. For the nine ASCII bytes "123456789" it is 0xD0DB.
- R4: With `cfg_wide`=1 the guard is a reflected CRC with polynomial 0x9A6C9329AC4BC9B5 (reflected form), all-ones seed and inverted result. For "123456789" it is 0xAE8B14860A799888.
- R5: The narrow tuple is 8 bytes, all big-endian: tuple offsets 0-1 hold the guard, 2-3 hold the application tag, and 4-7 hold the low 32 bits of the reference tag.
- R6: The wide tuple is 16 bytes: offsets 0-7 hold the guard, 8-9 hold the application tag, and 10-15 hold the 48-bit reference tag, all most significant byte first.
- R7: With `cfg_first`=1 the tuple occupies metadata bytes 0 to T-1 (T = 8 or 16), and the guard covers only the block's data bytes.
- R8: With `cfg_first`=0 the tuple occupies the last T metadata bytes. The metadata bytes before it are folded into the guard after the data bytes, continuing the same CRC state.
- R9: Metadata bytes outside the tuple pass through unchanged.
- R10: The reference tag starts at `cfg_ref_tag` for the first block. With `cfg_ptype`=3 it stays the same for all blocks; any other code adds one per block, wrapping at 48 bits.
- R11: `done` is high for exactly one cycle, in the same cycle as the output of the last metadata byte of the last block. The block then returns to idle.
- R12: A `start` pulse while busy is ignored.
- R13: The configuration inputs are sampled only at `start`; changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; loads configuration and tags |
| cfg_wide | input | 1 | 0: 16-bit guard format, 1: 64-bit guard format |
| cfg_first | input | 1 | 1: tuple at head of metadata, 0: at tail |
| cfg_ptype | input | 2 | Protection type; 3 keeps the reference tag fixed |
| cfg_blk_len | input | BLK_W (12) | Data bytes per block (at least 1) |
| cfg_meta_len | input | META_W (6) | Metadata bytes per block (at least the tuple size) |
| cfg_blk_cnt | input | CNT_W (8) | Number of blocks in the run (at least 1) |
| cfg_app_tag | input | 16 | Application tag written in every tuple |
| cfg_ref_tag | input | 48 | Reference tag of the first block |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input stream byte |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output stream byte with tuples inserted |
| done | output | 1 | One-cycle pulse with the last output byte |

## Verification
The assertions check on every cycle that `done` only appears with an output byte and in the idle state, and that the guard stays frozen while tuple bytes are emitted. They also check that a fixed reference tag never moves under protection type 3, that the configuration is held during a run, and that the metadata counter stays inside the configured length. The guard values and the tuple byte layouts can only be shown by the bench's scenarios. So can head versus tail placement with prefix folding, tag wrapping, tolerance of input gaps, and the ignoring of mid-run start and configuration changes. The bench compares every output byte against a model and checks published check values for both CRCs.

// File: rtl/pi_pkg.sv
package pi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_META = 2'd2
    } pi_state_e;

    localparam logic [15:0] GUARD16_POLY = 16'h8BB7;
    localparam logic [63:0] GUARD64_POLY = 64'h9A6C9329AC4BC9B5;
    localparam logic [1:0]  PTYPE_FIXED  = 2'd3;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) begin
            r = r[15] ? ((r << 1) ^ GUARD16_POLY) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic [63:0] crc64_step(input logic [63:0] c, input logic [7:0] b);
        logic [63:0] r;
        r = c ^ {56'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ GUARD64_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pi_crc_unit.sv
module pi_crc_unit #(
    parameter bit WIDE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [63:0] guard
);
    import pi_pkg::*;

    generate
        if (WIDE) begin : g_wide
            logic [63:0] st_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   st_q <= '1;
                else if (clr) st_q <= '1;
                else if (en)  st_q <= crc64_step(st_q, din);
            end
            assign guard = ~st_q;
        end else begin : g_narrow
            logic [15:0] st_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   st_q <= '0;
                else if (clr) st_q <= '0;
                else if (en)  st_q <= crc16_step(st_q, din);
            end
            assign guard = {48'h0, st_q};
        end
    endgenerate

endmodule

// File: rtl/pi_tuple_pack.sv
module pi_tuple_pack (
    input  logic        wide,
    input  logic [63:0] guard,
    input  logic [15:0] app_tag,
    input  logic [47:0] ref_tag,
    input  logic [3:0]  idx,
    output logic [7:0]  tbyte
);
    localparam int TUPLE_BITS = 128;

    logic [TUPLE_BITS-1:0] image;
    logic [TUPLE_BITS-1:0] shifted;

    always_comb begin
        if (wide) image = {guard, app_tag, ref_tag};
        else      image = {guard[15:0], app_tag, ref_tag[31:0], 64'h0};
        shifted = image << ({3'd0, idx} * 7'd8);
        tbyte   = shifted[TUPLE_BITS-1 -: 8];
    end

endmodule

// File: rtl/pi_tuple_gen.sv
module pi_tuple_gen #(
    parameter int BLK_W  = 12,
    parameter int META_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_wide,
    input  logic              cfg_first,
    input  logic [1:0]        cfg_ptype,
    input  logic [BLK_W-1:0]  cfg_blk_len,
    input  logic [META_W-1:0] cfg_meta_len,
    input  logic [CNT_W-1:0]  cfg_blk_cnt,
    input  logic [15:0]       cfg_app_tag,
    input  logic [47:0]       cfg_ref_tag,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              done
);
    import pi_pkg::*;

    localparam logic [META_W-1:0] TSZ_NARROW = META_W'(8);
    localparam logic [META_W-1:0] TSZ_WIDE   = META_W'(16);

    pi_state_e         state_q, state_d;
    logic              wide_q, first_q;
    logic [1:0]        ptype_q;
    logic [BLK_W-1:0]  blk_q, dcnt_q;
    logic [META_W-1:0] meta_q, mcnt_q;
    logic [CNT_W-1:0]  nblk_q, bcnt_q;
    logic [15:0]       app_q;
    logic [47:0]       ref_q;

    logic              accept, last_data, last_meta, last_blk, blk_end;
    logic [META_W-1:0] tsize, pre_len, toff;
    logic              in_tuple, crc_en, crc_clr;
    logic [63:0]       g16, g64, guard_sel;
    logic [7:0]        tbyte;

    assign accept    = in_valid && (state_q != ST_IDLE);
    assign last_data = (dcnt_q == blk_q - BLK_W'(1));
    assign last_meta = (mcnt_q == meta_q - META_W'(1));
    assign last_blk  = (bcnt_q == nblk_q - CNT_W'(1));
    assign blk_end   = accept && (state_q == ST_META) && last_meta;
    assign tsize     = wide_q ? TSZ_WIDE : TSZ_NARROW;
    assign pre_len   = meta_q - tsize;
    assign in_tuple  = (state_q == ST_META) && (first_q ? (mcnt_q < tsize) : (mcnt_q >= pre_len));
    assign toff      = first_q ? mcnt_q : (mcnt_q - pre_len);
    assign crc_en    = accept && ((state_q == ST_DATA) ||
                       ((state_q == ST_META) && !first_q && (mcnt_q < pre_len)));
    assign crc_clr   = ((state_q == ST_IDLE) && start) || blk_end;

    pi_crc_unit #(.WIDE(1'b0)) u_crc16 (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(in_byte), .guard(g16)
    );
    pi_crc_unit #(.WIDE(1'b1)) u_crc64 (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(in_byte), .guard(g64)
    );

    assign guard_sel = wide_q ? g64 : g16;

    pi_tuple_pack u_pack (
        .wide(wide_q), .guard(guard_sel), .app_tag(app_q), .ref_tag(ref_q),
        .idx(toff[3:0]), .tbyte(tbyte)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                state_d = ST_DATA;
            ST_DATA: if (accept && last_data)  state_d = ST_META;
            ST_META: if (blk_end)              state_d = last_blk ? ST_IDLE : ST_DATA;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // configuration, tags and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q <= 1'b0; first_q <= 1'b0; ptype_q <= '0;
            blk_q <= '0; meta_q <= '0; nblk_q <= '0;
            app_q <= '0; ref_q <= '0;
            dcnt_q <= '0; mcnt_q <= '0; bcnt_q <= '0;
        end else if (state_q == ST_IDLE) begin
            dcnt_q <= '0;
            mcnt_q <= '0;
            if (start) begin
                wide_q  <= cfg_wide;
                first_q <= cfg_first;
                ptype_q <= cfg_ptype;
                blk_q   <= cfg_blk_len;
                meta_q  <= cfg_meta_len;
                nblk_q  <= cfg_blk_cnt;
                app_q   <= cfg_app_tag;
                ref_q   <= cfg_ref_tag;
                bcnt_q  <= '0;
            end
        end else if (accept) begin
            if (state_q == ST_DATA) begin
                dcnt_q <= last_data ? '0 : dcnt_q + BLK_W'(1);
            end else begin
                mcnt_q <= last_meta ? '0 : mcnt_q + META_W'(1);
                if (last_meta) begin
                    bcnt_q <= bcnt_q + CNT_W'(1);
                    if (ptype_q != PTYPE_FIXED) ref_q <= ref_q + 48'd1;
                end
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= accept;
            done      <= blk_end && last_blk;
            if (accept) out_byte <= in_tuple ? tbyte : in_byte;
        end
    end

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE) && out_valid);

    p_ref_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && ptype_q == PTYPE_FIXED) |=> $stable(ref_q));

    p_guard_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_tuple && !last_meta) |=> $stable(guard_sel));

    p_cfg_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(blk_q) && $stable(meta_q) && $stable(wide_q) && $stable(app_q));

    p_meta_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_META) |-> (mcnt_q < meta_q));

    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !out_valid);

endmodule

// File: tb/tb_pi_tuple_gen.sv
module tb_pi_tuple_gen;

    typedef struct packed {
        logic        wide;
        logic        first;
        logic [1:0]  ptype;
        logic [11:0] blk;
        logic [5:0]  meta;
        logic [7:0]  nblk;
        logic [15:0] app;
        logic [47:0] rtag;
        logic [7:0]  seed;
        logic        disturb;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd1, 12'd16, 6'd8,  8'd3, 16'h1234, 48'h0000FFFFFFFE, 8'h11, 1'b0},
        '{1'b0, 1'b0, 2'd2, 12'd12, 6'd12, 8'd2, 16'hBEEF, 48'h000000000100, 8'h5A, 1'b1},
        '{1'b0, 1'b0, 2'd3, 12'd20, 6'd16, 8'd3, 16'h0F0F, 48'h0000CAFE0001, 8'h03, 1'b0},
        '{1'b1, 1'b1, 2'd1, 12'd32, 6'd16, 8'd2, 16'hA55A, 48'h123456789ABC, 8'h77, 1'b0},
        '{1'b1, 1'b0, 2'd3, 12'd24, 6'd24, 8'd3, 16'h0001, 48'h00000000FFFF, 8'hC3, 1'b1},
        '{1'b1, 1'b0, 2'd2, 12'd8,  6'd20, 8'd2, 16'hFFFE, 48'hFFFFFFFFFFFF, 8'h29, 1'b0},
        '{1'b0, 1'b1, 2'd0, 12'd1,  6'd10, 8'd4, 16'h8001, 48'h000000000007, 8'hE0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_wide = 1'b0, cfg_first = 1'b0;
    logic [1:0]  cfg_ptype = '0;
    logic [11:0] cfg_blk_len = '0;
    logic [5:0]  cfg_meta_len = '0;
    logic [7:0]  cfg_blk_cnt = '0;
    logic [15:0] cfg_app_tag = '0;
    logic [47:0] cfg_ref_tag = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        out_valid, done;
    logic [7:0]  out_byte;

    pi_tuple_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_wide(cfg_wide), .cfg_first(cfg_first), .cfg_ptype(cfg_ptype),
        .cfg_blk_len(cfg_blk_len), .cfg_meta_len(cfg_meta_len), .cfg_blk_cnt(cfg_blk_cnt),
        .cfg_app_tag(cfg_app_tag), .cfg_ref_tag(cfg_ref_tag),
        .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .done(done)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0] stim [0:511];
    logic [7:0] expv [0:511];
    int         tagc [0:511];
    logic [7:0] cap  [0:511];
    int cap_n = 0;
    int done_cnt = 0;
    int done_at = -1;
    bit mon_en = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (out_valid) begin
                cap[cap_n] = out_byte;
                cap_n++;
            end
            if (done) begin
                done_cnt++;
                done_at = cap_n - 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [15:0] ref_c16(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h8BB7) : (r << 1);
        return r;
    endfunction

    function automatic logic [63:0] ref_c64(input logic [63:0] c, input logic [7:0] b);
        logic [63:0] r = c ^ {56'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 64'h9A6C9329AC4BC9B5) : (r >> 1);
        return r;
    endfunction

    function automatic string tag_name(input int code, input logic wide, input logic first);
        case (code)
            0: return "R2";
            1: return "R9";
            2: return wide ? (first ? "R4/R7" : "R4/R8") : (first ? "R3/R7" : "R3/R8");
            3: return wide ? "R6" : "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp_v);
        end
    endtask

    // stream one run; kat selects the ASCII check string as data
    task automatic run_xfer(input vec_t v, input bit kat);
        int total;
        total = int'(v.nblk) * (int'(v.blk) + int'(v.meta));
        for (int i = 0; i < total; i++) begin
            int pos = i % (int'(v.blk) + int'(v.meta));
            if (kat) stim[i] = (pos < int'(v.blk)) ? 8'(8'h31 + pos) : 8'h00;
            else     stim[i] = 8'(v.seed + 8'(i * 7) + 8'(i >> 3));
        end
        cap_n = 0; done_cnt = 0; done_at = -1; mon_en = 1'b1;
        @(negedge clk);
        cfg_wide = v.wide; cfg_first = v.first; cfg_ptype = v.ptype;
        cfg_blk_len = v.blk; cfg_meta_len = v.meta; cfg_blk_cnt = v.nblk;
        cfg_app_tag = v.app; cfg_ref_tag = v.rtag; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < total; i++) begin
            if (i % 5 == 3) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = stim[i];
            if (v.disturb && i == 5) begin
                start = 1'b1;
                cfg_wide = ~v.wide; cfg_first = ~v.first; cfg_blk_len = v.blk + 12'd3;
                cfg_meta_len = 6'd40; cfg_app_tag = ~v.app; cfg_ref_tag = 48'h0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic build_expect(input vec_t v);
        int bl, tsz, pre, tpos;
        logic [47:0] rt;
        logic [127:0] img;
        logic [15:0] c16;
        logic [63:0] c64, g;
        bl  = int'(v.blk) + int'(v.meta);
        tsz = v.wide ? 16 : 8;
        pre = int'(v.meta) - tsz;
        rt  = v.rtag;
        for (int b = 0; b < int'(v.nblk); b++) begin
            int base = b * bl;
            c16 = 16'h0; c64 = '1;
            for (int i = 0; i < int'(v.blk); i++) begin
                expv[base + i] = stim[base + i]; tagc[base + i] = 0;
                c16 = ref_c16(c16, stim[base + i]); c64 = ref_c64(c64, stim[base + i]);
            end
            for (int j = 0; j < int'(v.meta); j++) begin
                expv[base + int'(v.blk) + j] = stim[base + int'(v.blk) + j];
                tagc[base + int'(v.blk) + j] = 1;
            end
            if (!v.first) begin
                for (int j = 0; j < pre; j++) begin
                    c16 = ref_c16(c16, stim[base + int'(v.blk) + j]);
                    c64 = ref_c64(c64, stim[base + int'(v.blk) + j]);
                end
            end
            g = v.wide ? ~c64 : {48'h0, c16};
            img = v.wide ? {g, v.app, rt} : {g[15:0], v.app, rt[31:0], 64'h0};
            tpos = base + int'(v.blk) + (v.first ? 0 : pre);
            for (int k = 0; k < tsz; k++) begin
                expv[tpos + k] = img[127 - 8*k -: 8];
                tagc[tpos + k] = v.wide ? ((k < 8) ? 2 : (k < 10) ? 3 : 4)
                                        : ((k < 2) ? 2 : (k < 4) ? 3 : 4);
            end
            if (v.ptype != 2'd3) rt = rt + 48'd1;
        end
    endtask

    task automatic compare_run(input vec_t v);
        int total;
        total = int'(v.nblk) * (int'(v.blk) + int'(v.meta));
        check(cap_n == total, "R2 byte count", cap_n, total);
        for (int i = 0; i < total; i++)
            check(cap[i] == expv[i], tag_name(tagc[i], v.wide, v.first), cap[i], expv[i]);
        check(done_cnt == 1, "R11 done count", done_cnt, 1);
        check(done_at == total - 1, "R11 done position", done_at, total - 1);
    endtask

    initial begin
        vec_t kv;
        logic [63:0] g64;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid at reset", out_valid, 0);
        check(done == 1'b0, "R1 done at reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: input while idle is ignored
        cap_n = 0; mon_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_byte = 8'(i + 8'h40);
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        mon_en = 1'b0;
        check(cap_n == 0, "R1 idle input ignored", cap_n, 0);

        // table walk: R2 R5 R6 R7 R8 R9 R10 R11, disturbed rows for R12 R13
        for (int n = 0; n < NV; n++) begin
            run_xfer(VECS[n], 1'b0);
            build_expect(VECS[n]);
            compare_run(VECS[n]);
        end

        // R3: narrow check value, tuple at head
        kv = '{1'b0, 1'b1, 2'd1, 12'd9, 6'd8, 8'd1, 16'h0000, 48'h0, 8'h00, 1'b0};
        run_xfer(kv, 1'b1);
        check({cap[9], cap[10]} == 16'hD0DB, "R3 check value", {cap[9], cap[10]}, 16'hD0DB);

        // R4: wide check value, tuple at head
        kv = '{1'b1, 1'b1, 2'd1, 12'd9, 6'd16, 8'd1, 16'h0000, 48'h0, 8'h00, 1'b0};
        run_xfer(kv, 1'b1);
        for (int k = 0; k < 8; k++) g64[63 - 8*k -: 8] = cap[9 + k];
        check(g64 == 64'hAE8B14860A799888, "R4 check value", g64, 64'hAE8B14860A799888);

        // R8: zero prefix before tail tuple still changes narrow guard vs head placement
        kv = '{1'b0, 1'b0, 2'd1, 12'd9, 6'd10, 8'd1, 16'h0000, 48'h0, 8'h00, 1'b0};
        run_xfer(kv, 1'b1);
        build_expect(kv);
        check({cap[11], cap[12]} == {expv[11], expv[12]}, "R8 prefix folded",
              {cap[11], cap[12]}, {expv[11], expv[12]});
        check({cap[11], cap[12]} != 16'hD0DB, "R8 prefix changes guard", {cap[11], cap[12]}, 16'hD0DB);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule